// File: doc/BRIEF.md
# Per-Line Sprite Selection Unit

This block picks the sprites that appear on one scanline. At the start of each line it walks a 32-entry sprite attribute table in memory from index 0 upward. It reads one vertical coordinate per memory grant and tests each one against the line number, using the current size and magnification settings. The first four sprites that cover the line are recorded by index only, in priority order. Slot 0 is the frontmost.

After the scan, the unit reads the table again for each recorded sprite. It fetches the vertical coordinate, horizontal coordinate, pattern number and colour byte. It then fetches one or two pattern bytes for the row of the sprite that falls on the current line. A fifth covering sprite ends the scan early and raises an overflow flag, which carries that sprite's index.

All memory traffic goes through a single request/grant port. An external slot scheduler owns the grant. Read data must be valid in the same cycle as the grant.

Top module: `sprite_line_select`

## Requirements
- R1: After a line start, each granted read during the scan uses address ATTR_BASE + 4*i (default ATTR_BASE 0x1B00), with i counting up by one from 0 and ending at 31 unless R4 stops it earlier.
- R2: A sprite with vertical coordinate Y covers line L when (L - Y) mod 256 < H. H is 8 when the size input is 0 and 16 when it is 1, and H doubles when the magnification input is 1.
- R3: Covering sprites fill slot 0, then 1, 2 and 3, in ascending index order. slot_vld_o bit k is set for each filled slot and slot_idx_o[k] holds that slot's sprite index.
- R4: When a fifth covering sprite is found, ovf_o goes to 1 and ovf_idx_o holds that sprite's index. No further scan reads are issued.
- R5: A line start clears every slot's valid bit, index and data bytes, as well as ovf_o, ovf_idx_o and done_o. Slots left unfilled stay invalid and all-zero.
- R6: For each filled slot, in slot order, four reads follow at ATTR_BASE + 4*idx + 0, +1, +2, +3. They land in slot_y_o, slot_x_o, slot_name_o and slot_color_o.
- R7: The pattern row is r = ((L - Y) mod 256) >> mag. With size 0, one read at PAT_BASE + 8*name + r (default PAT_BASE 0x3800) goes to slot_pat_l_o, and slot_pat_r_o stays 0. With size 1, two reads at PAT_BASE + 8*(name & 0xFC) + r and that address + 16 go to slot_pat_l_o and slot_pat_r_o.
- R8: busy_o is high from the cycle after a line start until the last fetch read is granted. done_o then stays high and mem_req_o stays low until the next line start.
- R9: line_i, size_i and mag_i are sampled only on the line start cycle. Changes to them during the scan or fetch have no effect.
- R10: While mem_req_o is high and the grant is low, the request and its address stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle pulse that begins a new line |
| line_i | input | 8 | Line number, sampled at line start |
| size_i | input | 1 | 0: 8x8 sprites, 1: 16x16 sprites |
| mag_i | input | 1 | 1: sprites drawn at double scale |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 14 | Read address |
| mem_gnt_i | input | 1 | Grant from the slot scheduler, read done this cycle |
| mem_rdata_i | input | 8 | Read data, valid with the grant |
| busy_o | output | 1 | Scan or fetch in progress |
| done_o | output | 1 | Line selection complete |
| slot_vld_o | output | 4 | Slot holds a selected sprite |
| slot_idx_o | output | 4x5 | Sprite index per slot |
| slot_y_o | output | 4x8 | Vertical coordinate per slot |
| slot_x_o | output | 4x8 | Horizontal coordinate per slot |
| slot_name_o | output | 4x8 | Pattern number per slot |
| slot_color_o | output | 4x8 | Colour / early-clock byte per slot |
| slot_pat_l_o | output | 4x8 | Left (or only) pattern byte per slot |
| slot_pat_r_o | output | 4x8 | Right pattern byte per slot (16x16 only) |
| ovf_o | output | 1 | A fifth covering sprite was found |
| ovf_idx_o | output | 5 | Index of that fifth sprite |

## Verification
A fault in the scan counter or the slot fill pointer shows up within one grant: the read address strays from the ascending table walk, or a sprite lands in the wrong slot. A fault in the fetch byte counter shows in the address of the very next read. It also leaves data bytes in the wrong output field. A hit test or row computation that is off by one changes which sprites are selected, or which pattern address is read. The bench finds this by sweeping lines across sprite edges, the 8-bit wrap, and every size and magnification setting.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int COORD_W = 8;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FETCH, ST_DONE} sps_state_e;
endpackage

// File: rtl/sps_hit_test.sv
module sps_hit_test
  import sps_pkg::*;
(
  input  logic [COORD_W-1:0] line_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic               size_i,
  input  logic               mag_i,
  output logic               hit_o,
  output logic [3:0]         row_o
);
  logic [COORD_W-1:0] diff;
  logic [5:0]         height;

  always_comb begin
    diff   = line_i - y_i;
    height = 6'd8 << ({1'b0, size_i} + {1'b0, mag_i});
    hit_o  = diff < COORD_W'(height);
    row_o  = mag_i ? diff[4:1] : diff[3:0];
  end
endmodule

// File: rtl/sps_slot_regs.sv
module sps_slot_regs #(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clr_i,
  input  logic                              push_i,
  input  logic [IDX_W-1:0]                  push_idx_i,
  output logic [NUM_SLOTS-1:0]              vld_o,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0]   idx_o,
  output logic [CNT_W-1:0]                  cnt_o,
  output logic                              full_o
);
  logic [CNT_W-1:0] cnt_q;

  assign full_o = (cnt_q == CNT_W'(NUM_SLOTS));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (push_i && !full_o) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[g] <= 1'b0;
        idx_o[g] <= '0;
      end else if (clr_i) begin
        vld_o[g] <= 1'b0;
        idx_o[g] <= '0;
      end else if (push_i && cnt_q == CNT_W'(g)) begin
        vld_o[g] <= 1'b1;
        idx_o[g] <= push_idx_i;
      end
    end

    if (g > 0) begin : g_ord
      AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o[g] |-> vld_o[g-1]);  // R3
    end
  end

  AST_ONE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(vld_o & ~$past(vld_o)) <= 1);  // R3
  AST_CNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(vld_o) == int'(cnt_q));  // R3
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (vld_o == '0 && cnt_q == '0));  // R5
endmodule

// File: rtl/sps_attr_store.sv
module sps_attr_store #(
  parameter int NUM_SLOTS = 4,
  parameter int SEL_W     = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  logic [SEL_W-1:0]              wr_slot_i,
  input  logic [2:0]                    wr_byte_i,
  input  logic [7:0]                    wr_data_i,
  output logic [NUM_SLOTS-1:0][7:0]     y_o,
  output logic [NUM_SLOTS-1:0][7:0]     x_o,
  output logic [NUM_SLOTS-1:0][7:0]     name_o,
  output logic [NUM_SLOTS-1:0][7:0]     color_o,
  output logic [NUM_SLOTS-1:0][7:0]     pat_l_o,
  output logic [NUM_SLOTS-1:0][7:0]     pat_r_o
);
  localparam int NBYTES = 6;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [NBYTES-1:0][7:0] byte_q;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      byte_q[b] <= '0;
        else if (clr_i)   byte_q[b] <= '0;
        else if (wr_i && wr_slot_i == SEL_W'(g) && wr_byte_i == 3'(b))
          byte_q[b] <= wr_data_i;
      end
    end

    assign y_o[g]     = byte_q[0];
    assign x_o[g]     = byte_q[1];
    assign name_o[g]  = byte_q[2];
    assign color_o[g] = byte_q[3];
    assign pat_l_o[g] = byte_q[4];
    assign pat_r_o[g] = byte_q[5];
  end
endmodule

// File: rtl/sprite_line_select.sv
module sprite_line_select
  import sps_pkg::*;
#(
  parameter int                NUM_SPR   = 32,
  parameter int                NUM_SLOTS = 4,
  parameter int                ADDR_W    = 14,
  parameter logic [ADDR_W-1:0] ATTR_BASE = 'h1B00,
  parameter logic [ADDR_W-1:0] PAT_BASE  = 'h3800,
  localparam int               IDX_W     = $clog2(NUM_SPR),
  localparam int               CNT_W     = $clog2(NUM_SLOTS + 1),
  localparam int               SEL_W     = $clog2(NUM_SLOTS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              line_start_i,
  input  logic [COORD_W-1:0]                line_i,
  input  logic                              size_i,
  input  logic                              mag_i,
  output logic                              mem_req_o,
  output logic [ADDR_W-1:0]                 mem_addr_o,
  input  logic                              mem_gnt_i,
  input  logic [7:0]                        mem_rdata_i,
  output logic                              busy_o,
  output logic                              done_o,
  output logic [NUM_SLOTS-1:0]              slot_vld_o,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0]   slot_idx_o,
  output logic [NUM_SLOTS-1:0][7:0]         slot_y_o,
  output logic [NUM_SLOTS-1:0][7:0]         slot_x_o,
  output logic [NUM_SLOTS-1:0][7:0]         slot_name_o,
  output logic [NUM_SLOTS-1:0][7:0]         slot_color_o,
  output logic [NUM_SLOTS-1:0][7:0]         slot_pat_l_o,
  output logic [NUM_SLOTS-1:0][7:0]         slot_pat_r_o,
  output logic                              ovf_o,
  output logic [IDX_W-1:0]                  ovf_idx_o
);
  sps_state_e         st_q;
  logic [IDX_W-1:0]   scan_idx_q;
  logic [SEL_W-1:0]   fslot_q;
  logic [2:0]         fbyte_q;
  logic [COORD_W-1:0] line_q;
  logic               size_q, mag_q;
  logic               ovf_q;
  logic [IDX_W-1:0]   ovf_idx_q;

  logic               hit;
  logic [3:0]         row;
  logic [COORD_W-1:0] test_y;
  logic [CNT_W-1:0]   slot_cnt;
  logic               slot_full;
  logic               push, store_wr;
  logic [2:0]         last_byte;
  logic [IDX_W-1:0]   cur_idx;
  logic [7:0]         cur_name;

  assign cur_idx   = slot_idx_o[fslot_q];
  assign cur_name  = slot_name_o[fslot_q];
  assign last_byte = size_q ? 3'd5 : 3'd4;
  // scan tests the byte on the bus; fetch re-tests the stored Y to get the row
  assign test_y    = (st_q == ST_SCAN) ? mem_rdata_i : slot_y_o[fslot_q];

  sps_hit_test u_hit (
    .line_i (line_q),
    .y_i    (test_y),
    .size_i (size_q),
    .mag_i  (mag_q),
    .hit_o  (hit),
    .row_o  (row)
  );

  assign push     = !line_start_i && st_q == ST_SCAN && mem_gnt_i && hit;
  assign store_wr = !line_start_i && st_q == ST_FETCH && mem_gnt_i && slot_cnt != '0;

  sps_slot_regs #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (line_start_i),
    .push_i     (push),
    .push_idx_i (scan_idx_q),
    .vld_o      (slot_vld_o),
    .idx_o      (slot_idx_o),
    .cnt_o      (slot_cnt),
    .full_o     (slot_full)
  );

  sps_attr_store #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (line_start_i),
    .wr_i      (store_wr),
    .wr_slot_i (fslot_q),
    .wr_byte_i (fbyte_q),
    .wr_data_i (mem_rdata_i),
    .y_o       (slot_y_o),
    .x_o       (slot_x_o),
    .name_o    (slot_name_o),
    .color_o   (slot_color_o),
    .pat_l_o   (slot_pat_l_o),
    .pat_r_o   (slot_pat_r_o)
  );

  always_comb begin
    mem_addr_o = ATTR_BASE + ADDR_W'({scan_idx_q, 2'b00});
    if (st_q == ST_FETCH) begin
      if (fbyte_q < 3'd4)
        mem_addr_o = ATTR_BASE + ADDR_W'({cur_idx, fbyte_q[1:0]});
      else if (size_q)
        mem_addr_o = PAT_BASE + ADDR_W'({cur_name[7:2], fbyte_q[0], row});
      else
        mem_addr_o = PAT_BASE + ADDR_W'({cur_name, row[2:0]});
    end
  end

  assign mem_req_o = !line_start_i &&
                     (st_q == ST_SCAN || (st_q == ST_FETCH && slot_cnt != '0));
  assign busy_o    = (st_q == ST_SCAN) || (st_q == ST_FETCH);
  assign done_o    = (st_q == ST_DONE);
  assign ovf_o     = ovf_q;
  assign ovf_idx_o = ovf_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      scan_idx_q <= '0;
      fslot_q    <= '0;
      fbyte_q    <= '0;
      line_q     <= '0;
      size_q     <= 1'b0;
      mag_q      <= 1'b0;
      ovf_q      <= 1'b0;
      ovf_idx_q  <= '0;
    end else if (line_start_i) begin
      st_q       <= ST_SCAN;
      scan_idx_q <= '0;
      fslot_q    <= '0;
      fbyte_q    <= '0;
      line_q     <= line_i;
      size_q     <= size_i;
      mag_q      <= mag_i;
      ovf_q      <= 1'b0;
      ovf_idx_q  <= '0;
    end else begin
      unique case (st_q)
        ST_SCAN: if (mem_gnt_i) begin
          if (hit && slot_full) begin
            ovf_q     <= 1'b1;
            ovf_idx_q <= scan_idx_q;
            st_q      <= ST_FETCH;
          end else if (scan_idx_q == IDX_W'(NUM_SPR - 1)) begin
            st_q <= ST_FETCH;
          end else begin
            scan_idx_q <= scan_idx_q + 1'b1;
          end
        end
        ST_FETCH: begin
          if (slot_cnt == '0) begin
            st_q <= ST_DONE;
          end else if (mem_gnt_i) begin
            if (fbyte_q == last_byte) begin
              fbyte_q <= '0;
              if (CNT_W'(fslot_q) == slot_cnt - CNT_W'(1)) st_q <= ST_DONE;
              else fslot_q <= fslot_q + 1'b1;
            end else begin
              fbyte_q <= fbyte_q + 3'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_SCAN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SCAN && mem_gnt_i && !line_start_i)
      |=> (st_q != ST_SCAN || scan_idx_q == $past(scan_idx_q) + 1'b1));  // R1
  AST_OVF_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (slot_full && st_q != ST_SCAN));  // R4
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && !line_start_i)
      |=> (line_start_i || (mem_req_o && $stable(mem_addr_o))));  // R10
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !line_start_i) |=> (done_o || busy_o));  // R8
endmodule

// File: tb/sprite_line_select_test.sv
`timescale 1ns/1ps
module sprite_line_select_test;
  localparam logic [13:0] AB = 14'h1B00;
  localparam logic [13:0] PB = 14'h3800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0;
  logic [7:0] line_in = '0;
  logic size_in = 1'b0, mag_in = 1'b0;
  logic mem_req, mem_gnt = 1'b0;
  logic [13:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic busy, done, ovf;
  logic [4:0] ovf_idx;
  logic [3:0] slot_vld;
  logic [3:0][4:0] slot_idx;
  logic [3:0][7:0] s_y, s_x, s_name, s_color, s_pl, s_pr;

  int checks = 0, errors = 0;
  logic [7:0] sat [0:127];
  logic [13:0] tr [0:63];
  int ntr = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  sprite_line_select uut (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(line_start), .line_i(line_in),
    .size_i(size_in), .mag_i(mag_in), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done),
    .slot_vld_o(slot_vld), .slot_idx_o(slot_idx), .slot_y_o(s_y), .slot_x_o(s_x),
    .slot_name_o(s_name), .slot_color_o(s_color), .slot_pat_l_o(s_pl),
    .slot_pat_r_o(s_pr), .ovf_o(ovf), .ovf_idx_o(ovf_idx)
  );

  function automatic logic [7:0] pat_byte(logic [13:0] a);
    return a[7:0] ^ 8'hA5 ^ {2'b00, a[13:8]};
  endfunction

  function automatic logic [7:0] mem_read(logic [13:0] a);
    logic [13:0] off = a - AB;
    if (a >= AB && a < AB + 14'd128) return sat[off[6:0]];
    return pat_byte(a);
  endfunction

  // grant and read data change only at the falling edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_gnt = lfsr[0] | lfsr[3];
    mem_rdata = mem_read(mem_addr);
    if (mem_req && mem_gnt && ntr < 64) begin
      tr[ntr] = mem_addr;
      ntr++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill_table(input int t);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] y;
      case (t)
        0: y = 8'(i * 9);
        1: y = 8'd100;
        2: y = (i < 28) ? 8'd200 : 8'(50 + i);
        default: y = 8'(250 - i);
      endcase
      sat[4*i]   = y;
      sat[4*i+1] = 8'(i * 3 + 1);
      sat[4*i+2] = 8'(i * 5 + 2);
      sat[4*i+3] = 8'(i ^ 8'h0F);
    end
  endtask

  task automatic run_line(input logic [7:0] l, input logic s, input logic m);
    int h, cnt, fifth, last, nexp;
    bit ov;
    int sel [4];
    logic [13:0] exp_a [0:63];
    logic [47:0] exp_d [4];
    h = (s ? 16 : 8) << m;
    cnt = 0; ov = 0; fifth = 0; last = 31; nexp = 0;
    for (int i = 0; i < 32; i++) begin
      logic [7:0] d = l - sat[4*i];
      if (int'(d) < h) begin
        if (cnt < 4) begin sel[cnt] = i; cnt++; end
        else begin ov = 1; fifth = i; last = i; break; end
      end
    end
    for (int i = 0; i <= last; i++) begin exp_a[nexp] = AB + 14'(4*i); nexp++; end
    for (int k = 0; k < 4; k++) begin
      exp_d[k] = '0;
      if (k < cnt) begin
        logic [7:0] yy, nm, d;
        logic [13:0] pl, pr;
        int r;
        yy = sat[4*sel[k]]; nm = sat[4*sel[k]+2];
        d = l - yy; r = int'(d) >> m;
        for (int b = 0; b < 4; b++) begin exp_a[nexp] = AB + 14'(4*sel[k] + b); nexp++; end
        if (s) begin
          pl = PB + 14'(8*(nm & 8'hFC) + r); pr = pl + 14'd16;
          exp_a[nexp] = pl; exp_a[nexp+1] = pr; nexp += 2;
        end else begin
          pl = PB + 14'(8*nm + r); pr = '0;
          exp_a[nexp] = pl; nexp++;
        end
        exp_d[k] = {yy, sat[4*sel[k]+1], nm, sat[4*sel[k]+3], pat_byte(pl), s ? pat_byte(pr) : 8'h00};
      end
    end

    @(negedge clk);
    line_in = l; size_in = s; mag_in = m; ntr = 0; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    line_in = l ^ 8'hC3; size_in = ~s; mag_in = ~m;  // R9: must be ignored
    chk(slot_vld == '0 && !ovf && ovf_idx == '0 && !done && s_y == '0 && s_pl == '0,
        "R5 clear on line start", {slot_vld, ovf, done}, 0);
    while (!done) @(negedge clk);

    chk(!busy && !mem_req, "R8 idle after done", {busy, mem_req}, 0);
    chk(ntr == nexp, "R1 R4 R9 read count", ntr, nexp);
    begin
      bit ok = 1; logic [13:0] a = 0, e = 0;
      for (int i = 0; i < nexp && i < ntr; i++)
        if (ok && tr[i] != exp_a[i]) begin ok = 0; a = tr[i]; e = exp_a[i]; end
      chk(ok, "R1 R6 R7 R10 read address order", a, e);
    end
    chk(slot_vld == 4'((1 << cnt) - 1), "R2 R3 R5 slot valid mask", slot_vld, (1 << cnt) - 1);
    for (int k = 0; k < 4; k++) begin
      logic [4:0] ei = (k < cnt) ? 5'(sel[k]) : 5'd0;
      chk(slot_idx[k] == ei, "R3 slot index", slot_idx[k], ei);
      chk({s_y[k], s_x[k], s_name[k], s_color[k], s_pl[k], s_pr[k]} == exp_d[k],
          "R6 R7 slot data", {s_y[k], s_x[k], s_name[k], s_color[k], s_pl[k], s_pr[k]}, exp_d[k]);
    end
    chk(ovf == ov && ovf_idx == (ov ? 5'(fifth) : 5'd0), "R4 overflow",
        {ovf, ovf_idx}, {ov, 5'(fifth)});
    repeat (2) @(negedge clk);
    chk(done && !mem_req, "R8 done holds", {done, mem_req}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && slot_vld == '0 && !ovf, "R5 R8 reset state",
        {busy, done, mem_req, slot_vld, ovf}, 0);
    for (int t = 0; t < 4; t++) begin
      fill_table(t);
      for (int c = 0; c < 4; c++)
        for (int l = 0; l < 256; l += 11)
          run_line(8'(l), c[0], c[1]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=not_done expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule